// File: doc/BRIEF.md
# Link Alarm Interrupt Aggregator

This block gathers the health signals of an optical link port and reduces them to one active-low interrupt line. Per-parameter monitor flags (already compared against their thresholds elsewhere), path fault bits and the three components of link health arrive as plain level inputs. Each is captured into a status register.

Event-type bits latch high and are cleared by reading their status register. Live-type bits follow their input. Each status bit passes a per-bit enable into a transmit or receive alarm. Those two alarms, together with a latched link-change event, pass a top-level enable into the interrupt.

Software reaches masks, enables and status through a small synchronous register port. A write takes effect at the clock edge where `reg_wr` is high. A read returns data combinationally while `reg_rd` is high, and it clears the latched bits of the register it reads at that same edge. The port has no stalls, so it carries no valid/ready pair. Every pin is a plain level.

Top module: `link_alarm_agg`

## Requirements
- R1: Register map on 3-bit addresses: 0 transmit flag mask, 1 receive flag mask, 2 transmit enable, 3 receive enable, 4 top enable, 5 transmit status, 6 receive status, 7 top status. After reset the enables read 0xFC (transmit), 0x1E (receive) and 0x00 (top), the masks read 0, and `irq_n` is 1.
- R2: Transmit status bit 0 is set when any bit of `tx_mon` (6 bits) is high while its bit in the transmit flag mask is 1. Unmasked monitor bits have no effect.
- R3: Receive status bit 0 is set when any bit of `rx_mon` (2 bits) is high while its bit in the receive flag mask is 1.
- R4: Latched bits stay set until their status register is read. A read clears them unless their condition is still present in that cycle. Transmit latched bits are 0 to 4, with bits 1 to 4 taken from `tx_evt[0..3]`. Receive latched bits are 0 to 4, with bits 1 to 4 taken from `rx_evt[0..3]`.
- R5: A latched bit whose condition occurs in the same cycle as the read of its register is still set after that read.
- R6: Top status bit 1 is the OR of transmit status AND transmit enable. Top status bit 2 is the OR of receive status AND receive enable.
- R7: Link is `sig_det & blk_lock & lane_align`. Top status bit 0 latches high whenever link changes in either direction, and it clears when top status is read.
- R8: `irq_n` is 0 exactly when (top status AND top enable) is nonzero over bits 0 to 2. It follows the status by one clock.
- R9: Unimplemented bits read as 0 and writes cannot set them. Writes to the status addresses have no effect. Transmit mask has 6 bits, receive mask 2, top enable 3, receive status/enable 5.
- R10: Transmit status bits 5 to 7 follow `tx_live[0..2]` one clock later without latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mon | input | 6 | Transmit monitor flags |
| rx_mon | input | 2 | Receive optical power flags |
| tx_evt | input | 4 | Transmit path fault events (latched) |
| tx_live | input | 3 | Transmit live fault levels |
| rx_evt | input | 4 | Receive path fault events (latched) |
| sig_det | input | 1 | Optical signal detected |
| blk_lock | input | 1 | Block lock achieved |
| lane_align | input | 1 | Lane alignment achieved |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears latched bits) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not reading |
| irq_n | output | 1 | Interrupt, low when asserted |

## Verification
The bench covers several corner cases, and each has a distinct failure signature:

- **Condition still present at read, or newly arriving in the read cycle.** A design that lets the clear win would lose the event, and the following read would return 0.
- **Monitor bit outside the mask.** A design that ignores the mask would latch the flag.
- **Link falling as well as rising.** A detector of one edge only would miss the fall.
- **Disabled enables.** Forgetting an enable would raise an alarm or the interrupt while it is disabled.
- **Reserved bits and writes to status addresses.** A design with loose decode would show stray ones.

// File: rtl/link_alarm_pkg.sv
package link_alarm_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_TXMASK  = 3'd0;
  localparam logic [AW-1:0] A_RXMASK  = 3'd1;
  localparam logic [AW-1:0] A_TXEN    = 3'd2;
  localparam logic [AW-1:0] A_RXEN    = 3'd3;
  localparam logic [AW-1:0] A_TOPEN   = 3'd4;
  localparam logic [AW-1:0] A_TXSTAT  = 3'd5;
  localparam logic [AW-1:0] A_RXSTAT  = 3'd6;
  localparam logic [AW-1:0] A_TOPSTAT = 3'd7;
  localparam int TOPW = 3;
endpackage

// File: rtl/sticky_bits.sv
module sticky_bits #(
  parameter int W = 8,
  parameter logic [W-1:0] LATCH = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LATCH[i]) begin : g_lh
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= cond[i] | (q[i] & ~clr);
      end
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= cond[i];
      end
    end
  end
endmodule

// File: rtl/masked_any.sv
module masked_any #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  input  logic [W-1:0] mask,
  output logic         any
);
  assign any = |(vec & mask);
endmodule

// File: rtl/link_watch.sv
module link_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det,
  input  logic blk_lock,
  input  logic lane_align,
  output logic changed
);
  logic link_now, link_q, seen_q;
  assign link_now = sig_det & blk_lock & lane_align;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      link_q <= link_now;
      seen_q <= 1'b1;
    end
  end
  assign changed = seen_q & (link_now ^ link_q);
endmodule

// File: rtl/link_alarm_agg.sv
module link_alarm_agg
  import link_alarm_pkg::*;
#(
  parameter int NTXM = 6,
  parameter int NRXM = 2,
  parameter int NTXE = 4,
  parameter int NTXL = 3,
  parameter int NRXE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTXM-1:0] tx_mon,
  input  logic [NRXM-1:0] rx_mon,
  input  logic [NTXE-1:0] tx_evt,
  input  logic [NTXL-1:0] tx_live,
  input  logic [NRXE-1:0] rx_evt,
  input  logic            sig_det,
  input  logic            blk_lock,
  input  logic            lane_align,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_n
);
  localparam int TXW = 1 + NTXE + NTXL;
  localparam int RXW = 1 + NRXE;
  localparam logic [TXW-1:0] TX_LATCH  = TXW'((1 << (1 + NTXE)) - 1);
  localparam logic [RXW-1:0] RX_LATCH  = '1;
  localparam logic [TXW-1:0] TX_EN_RST = TXW'(((1 << TXW) - 1) & ~3);
  localparam logic [RXW-1:0] RX_EN_RST = RXW'(((1 << RXW) - 1) & ~1);

  logic [NTXM-1:0] txmask_q;
  logic [NRXM-1:0] rxmask_q;
  logic [TXW-1:0]  txen_q, tx_stat;
  logic [RXW-1:0]  rxen_q, rx_stat;
  logic [TOPW-1:0] topen_q, top_stat;
  logic tx_flag, rx_flag, tx_alarm, rx_alarm, link_chg, ls_q, irq_q;
  logic rd_tx, rd_rx, rd_top;

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txmask_q <= '0;
      rxmask_q <= '0;
      txen_q   <= TX_EN_RST;
      rxen_q   <= RX_EN_RST;
      topen_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_TXMASK: txmask_q <= reg_wdata[NTXM-1:0];
        A_RXMASK: rxmask_q <= reg_wdata[NRXM-1:0];
        A_TXEN:   txen_q   <= reg_wdata[TXW-1:0];
        A_RXEN:   rxen_q   <= reg_wdata[RXW-1:0];
        A_TOPEN:  topen_q  <= reg_wdata[TOPW-1:0];
        default: ;
      endcase
    end
  end

  assign rd_tx  = reg_rd && (reg_addr == A_TXSTAT);
  assign rd_rx  = reg_rd && (reg_addr == A_RXSTAT);
  assign rd_top = reg_rd && (reg_addr == A_TOPSTAT);

  // first level: monitor flags
  masked_any #(.W(NTXM)) u_txflag (.vec(tx_mon), .mask(txmask_q), .any(tx_flag));
  masked_any #(.W(NRXM)) u_rxflag (.vec(rx_mon), .mask(rxmask_q), .any(rx_flag));

  // status capture
  sticky_bits #(.W(TXW), .LATCH(TX_LATCH)) u_txst (
    .clk(clk), .rst_n(rst_n), .cond({tx_live, tx_evt, tx_flag}), .clr(rd_tx), .q(tx_stat));
  sticky_bits #(.W(RXW), .LATCH(RX_LATCH)) u_rxst (
    .clk(clk), .rst_n(rst_n), .cond({rx_evt, rx_flag}), .clr(rd_rx), .q(rx_stat));

  link_watch u_link (.clk(clk), .rst_n(rst_n), .sig_det(sig_det), .blk_lock(blk_lock),
                     .lane_align(lane_align), .changed(link_chg));
  sticky_bits #(.W(1), .LATCH(1'b1)) u_ls (
    .clk(clk), .rst_n(rst_n), .cond(link_chg), .clr(rd_top), .q(ls_q));

  // second level: path alarms
  masked_any #(.W(TXW)) u_txal (.vec(tx_stat), .mask(txen_q), .any(tx_alarm));
  masked_any #(.W(RXW)) u_rxal (.vec(rx_stat), .mask(rxen_q), .any(rx_alarm));
  assign top_stat = {rx_alarm, tx_alarm, ls_q};

  // interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(top_stat & topen_q);
  end
  assign irq_n = ~irq_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_TXMASK:  reg_rdata = DW'(txmask_q);
        A_RXMASK:  reg_rdata = DW'(rxmask_q);
        A_TXEN:    reg_rdata = DW'(txen_q);
        A_RXEN:    reg_rdata = DW'(rxen_q);
        A_TOPEN:   reg_rdata = DW'(topen_q);
        A_TXSTAT:  reg_rdata = DW'(tx_stat);
        A_RXSTAT:  reg_rdata = DW'(rx_stat);
        default:   reg_rdata = DW'(top_stat);
      endcase
    end
  end
endmodule

// File: rtl/link_alarm_agg_chk.sv
module link_alarm_agg_chk
  import link_alarm_pkg::*;
#(
  parameter int NTXM = 6,
  parameter int TXW  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_rd,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic            irq_n,
  input logic            sig_det,
  input logic            blk_lock,
  input logic            lane_align,
  input logic [NTXM-1:0] tx_mon,
  input logic [NTXM-1:0] txmask,
  input logic [TXW-1:0]  tx_stat,
  input logic [TOPW-1:0] topen,
  input logic            ls
);
  logic link_now, prev_link, prev_ok;
  assign link_now = sig_det & blk_lock & lane_align;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_link <= 1'b0;
      prev_ok   <= 1'b0;
    end else begin
      prev_link <= link_now;
      prev_ok   <= 1'b1;
    end
  end

  AST_LS_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok && (link_now != prev_link) |=> ls); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stat[0] && !(reg_rd && reg_addr == A_TXSTAT) |=> tx_stat[0]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_TXSTAT && |(tx_mon & txmask) |=> tx_stat[0]); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(topen != '0)); // R8
  AST_RSVD_TOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_TOPEN |-> reg_rdata[DW-1:TOPW] == '0); // R9
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0); // R1
endmodule

bind link_alarm_agg link_alarm_agg_chk #(.NTXM(NTXM), .TXW(TXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_n(irq_n), .sig_det(sig_det), .blk_lock(blk_lock), .lane_align(lane_align),
  .tx_mon(tx_mon), .txmask(txmask_q), .tx_stat(tx_stat), .topen(topen_q), .ls(ls_q));

// File: tb/sim_link_alarm_agg.sv
`timescale 1ns/1ps
module sim_link_alarm_agg;
  logic clk = 0, rst_n = 0;
  logic [5:0] tx_mon = 0;
  logic [1:0] rx_mon = 0;
  logic [3:0] tx_evt = 0, rx_evt = 0;
  logic [2:0] tx_live = 0;
  logic sig_det = 0, blk_lock = 0, lane_align = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_n;
  int checks = 0, fails = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  link_alarm_agg u0 (.*);

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (reg_rd && rst_n) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: act=%02h exp=none", reg_rdata);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== 8'(e)) begin
          fails++;
          $display("FAIL %s: act=%02h exp=%02h", t, reg_rdata, 8'(e));
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input int e, input string t);
    @(posedge clk); #1;
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      fails++;
      $display("FAIL %s: irq_n act=%0b exp=%0b", t, irq_n, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: act=%0d pending exp=0", exp_q.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk_irq(1'b1, "R1 irq after reset");
    rd(3'd0, 8'h00, "R1 txmask");
    rd(3'd1, 8'h00, "R1 rxmask");
    rd(3'd2, 8'hFC, "R1 txen");
    rd(3'd3, 8'h1E, "R1 rxen");
    rd(3'd4, 8'h00, "R1 topen");
    rd(3'd5, 8'h00, "R1 txstat");
    rd(3'd6, 8'h00, "R1 rxstat");
    rd(3'd7, 8'h00, "R1 topstat");

    // R2 masked transmit flag
    wr(3'd0, 8'h05);
    tx_mon = 6'b000010; idle(2); tx_mon = 0;
    rd(3'd5, 8'h00, "R2 unmasked flag ignored");
    tx_mon = 6'b000100; idle(1); tx_mon = 0;
    rd(3'd5, 8'h01, "R2 masked flag latched");
    rd(3'd5, 8'h00, "R4 cleared by read");

    // R4 condition still present at read
    tx_mon = 6'b000001; idle(2);
    rd(3'd5, 8'h01, "R4 set while present");
    rd(3'd5, 8'h01, "R4 not cleared while present");
    tx_mon = 0; idle(2);
    rd(3'd5, 8'h01, "R4 held after drop");
    rd(3'd5, 8'h00, "R4 cleared after drop");

    // R3 receive flag
    wr(3'd1, 8'h02);
    rx_mon = 2'b01; idle(1); rx_mon = 0;
    rd(3'd6, 8'h00, "R3 unmasked rx flag ignored");
    rx_mon = 2'b10; idle(1); rx_mon = 0;
    rd(3'd6, 8'h01, "R3 rx flag latched");
    rd(3'd6, 8'h00, "R3 rx cleared");

    // R5 event in the read cycle survives
    @(posedge clk); #1;
    tx_evt = 4'b0010; reg_rd = 1; reg_addr = 3'd5;
    exp_q.push_back(8'h00); tag_q.push_back("R5 read before set");
    @(posedge clk); #1;
    tx_evt = 0; reg_rd = 0;
    rd(3'd5, 8'h04, "R5 event kept after read");
    rd(3'd5, 8'h00, "R5 cleared later");

    // R10 live bits
    tx_live = 3'b001; idle(2);
    rd(3'd5, 8'h20, "R10 live bit follows");
    rd(3'd5, 8'h20, "R10 live bit not cleared by read");
    tx_live = 0; idle(2);
    rd(3'd5, 8'h00, "R10 live bit drops");

    // R6 path alarms through enables
    rx_evt = 4'b0100; idle(1); rx_evt = 0;
    rd(3'd7, 8'h04, "R6 rx alarm");
    wr(3'd3, 8'h00);
    rd(3'd7, 8'h00, "R6 rx alarm disabled");
    wr(3'd3, 8'h1E);
    rd(3'd6, 8'h08, "R6 rx status bit3");
    tx_evt = 4'b0010; idle(1); tx_evt = 0;
    rd(3'd7, 8'h02, "R6 tx alarm");
    rd(3'd5, 8'h04, "R6 tx status bit2");
    rd(3'd7, 8'h00, "R6 tx alarm gone");

    // R8 interrupt
    rx_evt = 4'b0100; idle(1); rx_evt = 0;
    idle(2);
    chk_irq(1'b1, "R8 irq masked by top enable");
    wr(3'd4, 8'h04);
    idle(1);
    chk_irq(1'b0, "R8 irq from rx alarm");
    rd(3'd6, 8'h08, "R8 rx status read");
    idle(2);
    chk_irq(1'b1, "R8 irq released");
    wr(3'd4, 8'h00);

    // R7 link change
    sig_det = 1; blk_lock = 1; idle(2);
    rd(3'd7, 8'h00, "R7 partial link no change");
    lane_align = 1; idle(2);
    rd(3'd7, 8'h01, "R7 link rise latched");
    rd(3'd7, 8'h00, "R7 cleared by read");
    blk_lock = 0; idle(2);
    wr(3'd4, 8'h01);
    idle(1);
    chk_irq(1'b0, "R8 irq from link change");
    rd(3'd7, 8'h01, "R7 link fall latched");
    idle(2);
    chk_irq(1'b1, "R8 irq cleared after link read");

    // R9 reserved bits and status writes
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h3F, "R9 txmask width");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h03, "R9 rxmask width");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h07, "R9 topen width");
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h00, "R9 status write ignored");
    wr(3'd3, 8'hFF);
    rd(3'd3, 8'h1F, "R9 rxen width");
    idle(2);
    chk_irq(1'b1, "R9 no stray interrupt");
    idle(2);
    finish_run();
  end
endmodule